// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. It drives an N-bit trial code to an external digital-to-analog converter and, every clock, reads one comparator bit that says whether the analog input is at or above the analog level of that trial code. It performs a binary search from the most significant bit down to the least significant bit. Each bit is decided in exactly one clock, so a conversion always takes N cycles, whatever the input level.

A one-cycle `start` pulse, given while the controller is idle, begins a conversion. `busy` stays high for the N test cycles. At completion the final code is registered on `result` and `done` pulses for one cycle. The comparator sense is fixed. A high `cmp_keep` means the input exceeds the trial, so the bit under test stays set. A low `cmp_keep` clears it.

The controller has three states. ST_IDLE waits for `start`. ST_TEST covers the bits above bit 0. ST_LAST tests bit 0. The transitions are as follows:
- ST_IDLE goes to ST_TEST on `start`, or straight to ST_LAST when N is 1.
- ST_TEST stays in ST_TEST while more than one bit remains to be decided.
- ST_TEST goes to ST_LAST once only bit 0 is left.
- ST_LAST returns to ST_IDLE unconditionally, and asserts `done` and loads `result` on that transition.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to idle: `trial_code`, `result`, `busy` and `done` are all zero after that edge.
- R2: A `start` sampled high while idle (`busy` low) makes `trial_code` equal to only the most significant bit set (e.g. 8'h80 for N=8), and makes `busy` high, from the next cycle.
- R3: In a test cycle, a low `cmp_keep` clears the bit under test in the next cycle. A high `cmp_keep` leaves it set. The bit under test is the lowest set bit of `trial_code`.
- R4: After a bit above bit 0 is decided, the next lower bit is set to 1 as the new trial, and every bit already decided keeps its value.
- R5: `busy` stays high for exactly N consecutive cycles per conversion. `done` rises in the cycle right after the last of them, with `busy` low.
- R6: `done` is high for exactly one cycle per conversion. In that cycle `result` equals the searched code, which for an ideal comparator is min(input level, 2^N-1).
- R7: While idle and without `start`, `result` and `trial_code` hold their values. `trial_code` keeps the final code after completion, and `result` changes only at the completion of a conversion.
- R8: `start` is ignored while `busy` is high. The trial sequence, the cycle of `done` and the result are unchanged by it.
- R9: A `start` given in the same cycle that `done` is high is accepted, because the controller is idle then.
- R10: The width N is a parameter (default 8). For N=6 and an input of 37 codes, the trial sequence is 100000, 110000, 101000, 100100, 100110, 100101, and the result is 100101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, honoured only while idle |
| cmp_keep | input | 1 | Comparator: high when the input is at or above the trial level |
| trial_code | output | N | Trial code to the external DAC |
| result | output | N | Registered final code |
| busy | output | 1 | High during the N test cycles |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The hardest condition to reach from the ports is a `start` that arrives in the middle of a search. To produce it, the bench raises `start` on a chosen test cycle while the ideal comparator model keeps answering. It then compares every later trial code, the `done` cycle and the result against a sequence it computes itself. A second hard case is a `start` on the exact cycle of `done`. The bench gives it and then checks that a new search begins at once while the previous result is held. A reset in the middle of a search is also driven, to show the return to a clean idle state.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TEST = 2'd1,
        ST_LAST = 2'd2
    } sar_state_t;

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_ctrl_pkg::*;
#(
    parameter int N    = 8,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output sar_state_t      state,
    output logic [IDXW-1:0] bit_idx,
    output logic            load,
    output logic            step,
    output logic            finish
);

    localparam logic [IDXW-1:0] TOP_IDX = IDXW'(N - 1);
    localparam logic [IDXW-1:0] ONE_IDX = IDXW'(1);

    sar_state_t      state_q;
    logic [IDXW-1:0] idx_q;

    // State register and bit index
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q   <= TOP_IDX;
                        state_q <= (N == 1) ? ST_LAST : ST_TEST;
                    end
                end
                ST_TEST: begin
                    idx_q <= idx_q - ONE_IDX;
                    if (idx_q == ONE_IDX) begin
                        state_q <= ST_LAST;
                    end
                end
                ST_LAST: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Control outputs decoded from the state
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        finish = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_TEST: step = 1'b1;
            ST_LAST: begin
                step   = 1'b1;
                finish = 1'b1;
            end
            default: begin
                load = 1'b0;
            end
        endcase
    end

    assign state   = state_q;
    assign bit_idx = idx_q;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int N    = 8,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [IDXW-1:0] bit_idx,
    input  logic            cmp_keep,
    output logic [N-1:0]    trial,
    output logic [N-1:0]    trial_next
);

    logic [N-1:0] trial_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            if (load) begin
                trial_next[i] = (i == N - 1);
            end else if (step && (int'(bit_idx) == i)) begin
                trial_next[i] = cmp_keep;
            end else if (step && (int'(bit_idx) == i + 1)) begin
                trial_next[i] = 1'b1;
            end else begin
                trial_next[i] = trial_q[i];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                trial_q[i] <= 1'b0;
            end else begin
                trial_q[i] <= trial_next[i];
            end
        end
    end

    assign trial = trial_q;

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         finish,
    input  logic [N-1:0] final_code,
    output logic [N-1:0] result,
    output logic         done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                result <= final_code;
            end
        end
    end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         cmp_keep,
    output logic [N-1:0] trial_code,
    output logic [N-1:0] result,
    output logic         busy,
    output logic         done
);

    localparam int IDXW = (N > 1) ? $clog2(N) : 1;

    sar_state_t      state;
    logic [IDXW-1:0] bit_idx;
    logic            load;
    logic            step;
    logic            finish;
    logic [N-1:0]    trial_next;

    sar_seq_fsm #(.N(N), .IDXW(IDXW)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .state   (state),
        .bit_idx (bit_idx),
        .load    (load),
        .step    (step),
        .finish  (finish)
    );

    sar_trial_reg #(.N(N), .IDXW(IDXW)) u_trial (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (step),
        .bit_idx    (bit_idx),
        .cmp_keep   (cmp_keep),
        .trial      (trial_code),
        .trial_next (trial_next)
    );

    sar_result_reg #(.N(N)) u_result (
        .clk        (clk),
        .rst        (rst),
        .finish     (finish),
        .final_code (trial_next),
        .result     (result),
        .done       (done)
    );

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         cmp_keep,
    input logic [N-1:0] trial_code,
    input logic [N-1:0] result,
    input logic         busy,
    input logic         done
);

    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    int           busy_cnt;
    logic [N-1:0] lsb_now;
    logic [N-1:0] lsb_q;
    logic [N-1:0] trial_q;
    logic [N-1:0] upper_mask;

    assign lsb_now    = trial_code & ~(trial_code - 1'b1);
    assign upper_mask = ~((lsb_q << 1) - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= 0;
            lsb_q    <= '0;
            trial_q  <= '0;
        end else begin
            busy_cnt <= busy ? busy_cnt + 1 : 0;
            lsb_q    <= lsb_now;
            trial_q  <= trial_code;
        end
    end

    // R2
    launch_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && trial_code == MSB_ONLY));

    // R3
    clear_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmp_keep) |=> ((trial_code & lsb_q) == '0));

    // R3
    keep_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmp_keep) |=> ((trial_code & lsb_q) != '0));

    // R4
    next_trial_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt < N - 1) |=>
            (((trial_code & (lsb_q >> 1)) != '0) &&
             ((trial_code & upper_mask) == (trial_q & upper_mask))));

    // R5
    busy_span_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt < N - 1) |=> busy);

    // R5
    finish_time_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_cnt == N - 1) |=> (done && !busy));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(result) && $stable(trial_code)));

endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cmp_keep   (cmp_keep),
    .trial_code (trial_code),
    .result     (result),
    .busy       (busy),
    .done       (done)
);

// File: tb/sar_ctrl_test.sv
`timescale 1ns/1ps
module sar_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start8 = 1'b0;
    logic       start6 = 1'b0;
    int         lvl8 = 0;
    int         lvl6 = 0;
    logic       cmp8;
    logic       cmp6;
    logic [7:0] trial8;
    logic [7:0] res8;
    logic       busy8;
    logic       done8;
    logic [5:0] trial6;
    logic [5:0] res6;
    logic       busy6;
    logic       done6;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // Ideal comparator models: keep the bit when the level reaches the trial
    assign cmp8 = (lvl8 >= int'(trial8));
    assign cmp6 = (lvl6 >= int'(trial6));

    sar_ctrl #(.N(8)) uut (
        .clk(clk), .rst(rst), .start(start8), .cmp_keep(cmp8),
        .trial_code(trial8), .result(res8), .busy(busy8), .done(done8)
    );

    sar_ctrl #(.N(6)) uut6 (
        .clk(clk), .rst(rst), .start(start6), .cmp_keep(cmp6),
        .trial_code(trial6), .result(res6), .busy(busy6), .done(done6)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int trial_at(input int n, input int lvl, input int k);
        int code = 0;
        int t = 0;
        for (int i = n - 1; i >= n - 1 - k; i--) begin
            t = code | (1 << i);
            if (i > n - 1 - k && lvl >= t) code = t;
        end
        return t;
    endfunction

    function automatic int final_of(input int n, input int lvl);
        int mx = (1 << n) - 1;
        return (lvl > mx) ? mx : lvl;
    endfunction

    // Entered at the negedge after the accepting edge; leaves at the done negedge
    task automatic track8(input int lvl, input int poke_at, input int prev_res);
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            start8 = (k == poke_at);
            chk("R4 trial8 sequence", int'(trial8), trial_at(8, lvl, k));
            chk("R5 busy8 during search", int'(busy8), 1);
            chk("R7 result held during search", int'(res8), prev_res);
            if (poke_at >= 0) chk("R8 start ignored, no early done", int'(done8), 0);
        end
        @(negedge clk);
        start8 = 1'b0;
        chk("R5 done8 after N cycles", int'(done8), 1);
        chk("R5 busy8 low at done", int'(busy8), 0);
        chk("R6 result8 value", int'(res8), final_of(8, lvl));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 trial8 at reset", int'(trial8), 0);
        chk("R1 result8 at reset", int'(res8), 0);
        chk("R1 busy8 at reset", int'(busy8), 0);
        chk("R1 done8 at reset", int'(done8), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_convert(input int lvl);
        int prev = int'(res8);
        lvl8 = lvl;
        start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
        chk("R2 trial8 MSB only after start", int'(trial8), 8'h80);
        track8(lvl, -1, prev);
        @(negedge clk);
        chk("R6 done8 one cycle only", int'(done8), 0);
        chk("R7 result8 held when idle", int'(res8), final_of(8, lvl));
        chk("R7 trial8 keeps final code", int'(trial8), final_of(8, lvl));
    endtask

    task automatic t_start_ignored(input int lvl, input int poke);
        int prev = int'(res8);
        lvl8 = lvl;
        start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
        track8(lvl, poke, prev);
        @(negedge clk);
        chk("R8 no restart from ignored start", int'(busy8), 0);
    endtask

    task automatic t_back_to_back(input int lvl_a, input int lvl_b);
        int prev = int'(res8);
        lvl8 = lvl_a;
        start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
        track8(lvl_a, -1, prev);
        lvl8 = lvl_b;
        start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
        chk("R9 start on done cycle accepted", int'(busy8), 1);
        track8(lvl_b, -1, final_of(8, lvl_a));
        @(negedge clk);
    endtask

    task automatic t_reset_mid;
        lvl8 = 200;
        start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 trial8 after mid reset", int'(trial8), 0);
        chk("R1 busy8 after mid reset", int'(busy8), 0);
        chk("R1 result8 after mid reset", int'(res8), 0);
        chk("R1 done8 after mid reset", int'(done8), 0);
        @(negedge clk);
    endtask

    task automatic t_six_bit;
        int seq [6] = '{6'b100000, 6'b110000, 6'b101000, 6'b100100, 6'b100110, 6'b100101};
        lvl6 = 37;
        start6 = 1'b1;
        @(negedge clk);
        start6 = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (k > 0) @(negedge clk);
            chk("R10 six-bit trial sequence", int'(trial6), seq[k]);
        end
        @(negedge clk);
        chk("R10 six-bit done", int'(done6), 1);
        chk("R10 six-bit result", int'(res6), 6'b100101);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_convert(0);
        t_convert(255);
        t_convert(300);
        t_convert(128);
        t_convert(127);
        t_convert(170);
        t_convert(37);
        t_start_ignored(90, 3);
        t_start_ignored(201, 7);
        t_back_to_back(66, 155);
        t_reset_mid();
        t_six_bit();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule